// File: doc/BRIEF.md
# Segmented Triggered Trace Capture Controller

This block is an on-chip debug capture unit. While a capture run is active it samples several probe lanes into internal storage. Each lane sampled in a cycle goes into its own storage entry, so lanes never share a word. A free-running cycle counter supplies the time reference. A capture cycle is chosen by one of three trigger selections: the cycle counter lying inside a programmed window, an event strobe, or both together.

Storage works in one of two modes. In windowed mode it is split into equal segments. Each segment has its own open and close cycle, fills from its first row, and stops when full. In circular mode all rows form one ring that keeps the latest captures. A done or error input ends the run. The stored entries then leave one bit at a time over a valid/ready serial link. A bit is only consumed in a cycle where the receiver raises ready, so a slow receiver stalls the unload and no data is lost.

Top module: `dbg_trace_capture`

## Requirements
- R1: The cycle counter is cleared by reset and by an accepted start, then increases by one every clock. The cycle after an accepted start reads 0. Window limits are inclusive at both ends.
- R2: The mode register is at config address 0. Bit 0 selects circular mode and bits 2:1 select the trigger: 0 means the counter is inside the window, 1 means `event_i` is high, and 2 or 3 means both conditions hold.
- R3: In windowed mode, segment s has its open cycle at address 2+2s and its close cycle at address 3+2s. It stores a captured row only in a cycle that qualifies under its own window. Each segment has its own rows.
- R4: A segment that holds ROWS rows stores nothing further. A qualifying cycle while it is full sets `seg_ovf_o[s]`, which stays set until the next accepted start.
- R5: In circular mode, segment 0's window supplies the time condition and every row of all segments forms one ring. Writing wraps around, and unload sends the oldest held row first and the newest last.
- R6: Every captured row holds one entry per lane, each DATA_W bits wide. Unload sends lane 0 of a row first and then the higher lanes in order.
- R7: `start_i` is accepted only while idle. `done_i` or `err_i` is acted on only during capture. It ends capture at that clock edge without storing that cycle's sample, and unload begins in the next cycle.
- R8: In windowed mode, unload sends segment 0's rows oldest first, then segment 1's, and so on. Empty segments send nothing. When the last entry has been sent, the block returns to idle.
- R9: Each entry is sent LSB first. A bit moves on only on a clock where `ser_valid_o` and `ser_ready_i` are both high. While ready is low, `ser_valid_o` and `ser_data_o` hold their values.
- R10: Config writes take effect only while idle. A write during capture or unload leaves all settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | CFG_AW | Config register address |
| cfg_wdata | input | CNT_W | Config write data |
| start_i | input | 1 | Begin a capture run |
| done_i | input | 1 | Test finished; stop and unload |
| err_i | input | 1 | Error flagged; stop and unload |
| probe_i | input | LANES*DATA_W | Probe lanes, lane 0 in the low bits |
| event_i | input | 1 | Event strobe used by the trigger |
| ser_valid_o | output | 1 | Serial bit is valid |
| ser_ready_i | input | 1 | Receiver accepts the bit |
| ser_data_o | output | 1 | Serial data bit |
| capturing_o | output | 1 | Capture run active |
| unloading_o | output | 1 | Unload active |
| seg_ovf_o | output | NSEG | Per-segment overflow flags |

## Verification
The lanes driven in the cycle where the counter reads k are written at the edge that closes that cycle. The bench therefore keeps its own cycle index, set to 0 on the cycle after the start edge, and computes the expected contents from that index. The stop input takes effect at its own edge: capture and unload flags change at the next negative edge, when they are sampled. Serial bits are read at each negative edge. A bit counts as transferred only if ready was driven high at that same negative edge. A stalled bit is compared with its value from the previous cycle. The overflow flags are read in the first unload cycle, and the word count is checked after the unload flag falls.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CAPTURE, PH_UNLOAD} phase_e;
  localparam logic [1:0] TRIG_WINDOW = 2'd0;
  localparam logic [1:0] TRIG_EVENT  = 2'd1;
endpackage

// File: rtl/dbg_trace_cfg.sv
module dbg_trace_cfg #(
  parameter int NSEG   = 2,
  parameter int CNT_W  = 16,
  parameter int CFG_AW = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            idle,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [CNT_W-1:0]                cfg_wdata,
  output logic                            circ_o,
  output logic [1:0]                      trig_sel_o,
  output logic [NSEG-1:0][CNT_W-1:0]      win_lo_o,
  output logic [NSEG-1:0][CNT_W-1:0]      win_hi_o
);
  logic wr_ok;
  assign wr_ok = idle && cfg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      circ_o     <= 1'b0;
      trig_sel_o <= 2'd0;
    end else if (wr_ok && cfg_addr == '0) begin
      circ_o     <= cfg_wdata[0];
      trig_sel_o <= cfg_wdata[2:1];
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_win
    localparam logic [CFG_AW-1:0] LO_ADDR = CFG_AW'(2 + 2 * s);
    localparam logic [CFG_AW-1:0] HI_ADDR = CFG_AW'(3 + 2 * s);
    logic [CNT_W-1:0] lo_q, hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_ok) begin
        if (cfg_addr == LO_ADDR) lo_q <= cfg_wdata;
        if (cfg_addr == HI_ADDR) hi_q <= cfg_wdata;
      end
    end
    assign win_lo_o[s] = lo_q;
    assign win_hi_o[s] = hi_q;
  end

  // R10: settings frozen outside idle
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable({circ_o, trig_sel_o, win_lo_o, win_hi_o}));
endmodule

// File: rtl/dbg_trace_seg.sv
module dbg_trace_seg
  import dbg_trace_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ROWS   = 8,
  parameter int FILL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_en,
  input  logic              circ,
  input  logic [1:0]        trig_sel,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  win_lo,
  input  logic [CNT_W-1:0]  win_hi,
  input  logic              event_i,
  output logic              hit_o,
  output logic              we_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              ovf_o
);
  logic in_win, full, qual;

  assign in_win = (cnt >= win_lo) && (cnt <= win_hi);
  always_comb begin
    unique case (trig_sel)
      TRIG_WINDOW: hit_o = in_win;
      TRIG_EVENT:  hit_o = event_i;
      default:     hit_o = in_win && event_i;
    endcase
  end

  assign full = (fill_o == FILL_W'(ROWS));
  assign qual = cap_en && !circ && hit_o;
  assign we_o = qual && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_o <= '0;
      ovf_o  <= 1'b0;
    end else if (clear) begin
      fill_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (we_o)         fill_o <= fill_o + 1'b1;
      if (qual && full) ovf_o  <= 1'b1;
    end
  end

  // R4: fill never passes the segment size
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= FILL_W'(ROWS));
  // R4: overflow only appears after a qualifying cycle on a full segment
  p_ovf_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(fill_o) == FILL_W'(ROWS));
  // R3: a time-gated write lies inside the window
  p_write_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && trig_sel != TRIG_EVENT) |-> (cnt >= win_lo && cnt <= win_hi));
endmodule

// File: rtl/dbg_trace_store.sv
module dbg_trace_store #(
  parameter int NSEG     = 2,
  parameter int LANES    = 2,
  parameter int DATA_W   = 32,
  parameter int TOT_ROWS = 16,
  parameter int TR_W     = 4,
  parameter int LANE_W   = 1
) (
  input  logic                           clk,
  input  logic [NSEG-1:0]                wr_en,
  input  logic [NSEG-1:0][TR_W-1:0]      wr_row,
  input  logic [LANES*DATA_W-1:0]        wdata,
  input  logic [TR_W-1:0]                rd_row,
  input  logic [LANE_W-1:0]              rd_lane,
  output logic [DATA_W-1:0]              rd_word
);
  logic [DATA_W-1:0] mem [TOT_ROWS*LANES];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSEG; s++) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[s]) mem[{wr_row[s], LANE_W'(l)}] <= wdata[l*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_word = mem[{rd_row, rd_lane}];
endmodule

// File: rtl/dbg_trace_unload.sv
module dbg_trace_unload #(
  parameter int NSEG   = 2,
  parameter int LANES  = 2,
  parameter int DATA_W = 32,
  parameter int ROW_W  = 3,
  parameter int SEG_W  = 1,
  parameter int TR_W   = 4,
  parameter int FILL_W = 4,
  parameter int LANE_W = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic                        circ,
  input  logic [NSEG-1:0][FILL_W-1:0] fill,
  input  logic [TR_W-1:0]             circ_base,
  input  logic [TR_W:0]               circ_count,
  input  logic [DATA_W-1:0]           rd_word,
  input  logic                        ser_ready_i,
  output logic [TR_W-1:0]             rd_row,
  output logic [LANE_W-1:0]           rd_lane,
  output logic                        ser_valid_o,
  output logic                        ser_data_o,
  output logic                        fin_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic              active;
  logic [SEG_W-1:0]  seg;
  logic [TR_W:0]     idx;
  logic [LANE_W-1:0] lane;
  logic [BIT_W-1:0]  bitc;
  logic [TR_W:0]     cur_len;
  logic              last_seg, have;
  logic [TR_W-1:0]   ring_row;

  assign cur_len  = circ ? circ_count : (TR_W+1)'(fill[seg]);
  assign last_seg = circ || (seg == SEG_W'(NSEG - 1));
  assign have     = active && (idx < cur_len);
  assign ring_row = circ_base + idx[TR_W-1:0];
  assign rd_row   = circ ? ring_row : {seg, idx[ROW_W-1:0]};
  assign rd_lane  = lane;

  assign ser_valid_o = have;
  assign ser_data_o  = have && rd_word[bitc];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      seg    <= '0;
      idx    <= '0;
      lane   <= '0;
      bitc   <= '0;
      fin_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go) begin
        active <= 1'b1;
        seg    <= '0;
        idx    <= '0;
        lane   <= '0;
        bitc   <= '0;
      end else if (active) begin
        if (!have) begin
          if (last_seg) begin
            active <= 1'b0;
            fin_o  <= 1'b1;
          end else begin
            seg <= seg + 1'b1;
            idx <= '0;
          end
        end else if (ser_ready_i) begin
          if (bitc == BIT_W'(DATA_W - 1)) begin
            bitc <= '0;
            if (lane == LANE_W'(LANES - 1)) begin
              lane <= '0;
              idx  <= idx + 1'b1;
            end else begin
              lane <= lane + 1'b1;
            end
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
      end
    end
  end

  // R9: a stalled bit holds value and validity
  p_ser_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid_o && !ser_ready_i) |=> (ser_valid_o && $stable(ser_data_o)));
endmodule

// File: rtl/dbg_trace_capture.sv
module dbg_trace_capture
  import dbg_trace_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 2,
  parameter int NSEG   = 2,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 16,
  parameter int CFG_AW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [CNT_W-1:0]        cfg_wdata,
  input  logic                    start_i,
  input  logic                    done_i,
  input  logic                    err_i,
  input  logic [LANES*DATA_W-1:0] probe_i,
  input  logic                    event_i,
  output logic                    ser_valid_o,
  input  logic                    ser_ready_i,
  output logic                    ser_data_o,
  output logic                    capturing_o,
  output logic                    unloading_o,
  output logic [NSEG-1:0]         seg_ovf_o
);
  localparam int ROWS     = DEPTH / (NSEG * LANES);
  localparam int ROW_W    = $clog2(ROWS);
  localparam int SEG_W    = $clog2(NSEG);
  localparam int TR_W     = SEG_W + ROW_W;
  localparam int TOT_ROWS = NSEG * ROWS;
  localparam int LANE_W   = $clog2(LANES);
  localparam int FILL_W   = ROW_W + 1;

  phase_e                      phase;
  logic [CNT_W-1:0]            cnt;
  logic                        start_ok, stop, cap_en, fin;
  logic                        circ;
  logic [1:0]                  trig_sel;
  logic [NSEG-1:0][CNT_W-1:0]  win_lo, win_hi;
  logic [NSEG-1:0]             hit, seg_we, wr_en;
  logic [NSEG-1:0][FILL_W-1:0] fill;
  logic [NSEG-1:0][TR_W-1:0]   wr_row;
  logic [TR_W-1:0]             wptr, rd_row, circ_base;
  logic                        wrapped;
  logic [TR_W:0]               circ_count;
  logic [LANE_W-1:0]           rd_lane;
  logic [DATA_W-1:0]           rd_word;

  assign start_ok = start_i && (phase == PH_IDLE);
  assign stop     = (phase == PH_CAPTURE) && (done_i || err_i);
  assign cap_en   = (phase == PH_CAPTURE) && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else begin
      unique case (phase)
        PH_IDLE:    if (start_ok) phase <= PH_CAPTURE;
        PH_CAPTURE: if (stop)     phase <= PH_UNLOAD;
        default:    if (fin)      phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (start_ok) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  dbg_trace_cfg #(.NSEG(NSEG), .CNT_W(CNT_W), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .idle(phase == PH_IDLE), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .circ_o(circ),
    .trig_sel_o(trig_sel), .win_lo_o(win_lo), .win_hi_o(win_hi));

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    dbg_trace_seg #(.CNT_W(CNT_W), .ROWS(ROWS), .FILL_W(FILL_W)) u_seg (
      .clk(clk), .rst_n(rst_n), .clear(start_ok), .cap_en(cap_en), .circ(circ),
      .trig_sel(trig_sel), .cnt(cnt), .win_lo(win_lo[s]), .win_hi(win_hi[s]),
      .event_i(event_i), .hit_o(hit[s]), .we_o(seg_we[s]), .fill_o(fill[s]),
      .ovf_o(seg_ovf_o[s]));
    if (s == 0) begin : g_ring_port
      assign wr_en[s] = circ ? (cap_en && hit[0]) : seg_we[s];
    end else begin : g_plain_port
      assign wr_en[s] = !circ && seg_we[s];
    end
    assign wr_row[s] = circ ? wptr : {SEG_W'(s), fill[s][ROW_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      wrapped <= 1'b0;
    end else if (start_ok) begin
      wptr    <= '0;
      wrapped <= 1'b0;
    end else if (cap_en && circ && hit[0]) begin
      wptr <= wptr + 1'b1;
      if (wptr == TR_W'(TOT_ROWS - 1)) wrapped <= 1'b1;
    end
  end

  assign circ_base  = wrapped ? wptr : '0;
  assign circ_count = wrapped ? (TR_W+1)'(TOT_ROWS) : {1'b0, wptr};

  dbg_trace_store #(.NSEG(NSEG), .LANES(LANES), .DATA_W(DATA_W),
    .TOT_ROWS(TOT_ROWS), .TR_W(TR_W), .LANE_W(LANE_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_row(wr_row), .wdata(probe_i),
    .rd_row(rd_row), .rd_lane(rd_lane), .rd_word(rd_word));

  dbg_trace_unload #(.NSEG(NSEG), .LANES(LANES), .DATA_W(DATA_W), .ROW_W(ROW_W),
    .SEG_W(SEG_W), .TR_W(TR_W), .FILL_W(FILL_W), .LANE_W(LANE_W)) u_unload (
    .clk(clk), .rst_n(rst_n), .go(stop), .circ(circ), .fill(fill),
    .circ_base(circ_base), .circ_count(circ_count), .rd_word(rd_word),
    .ser_ready_i(ser_ready_i), .rd_row(rd_row), .rd_lane(rd_lane),
    .ser_valid_o(ser_valid_o), .ser_data_o(ser_data_o), .fin_o(fin));

  assign capturing_o = (phase == PH_CAPTURE);
  assign unloading_o = (phase == PH_UNLOAD);

  // R1: accepted start restarts the counter
  p_cnt_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (cnt == '0));
  // R7: a stop during capture leads straight to unload
  p_stop_unload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing_o && (done_i || err_i)) |=> (unloading_o && !capturing_o));
  // R9: no serial traffic outside unload
  p_quiet_serial_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !unloading_o |-> !ser_valid_o);
endmodule

// File: tb/dbg_trace_capture_tb.sv
`timescale 1ns/1ps
module dbg_trace_capture_tb;
  localparam int DATA_W = 32, LANES = 2, NSEG = 2, DEPTH = 32, CNT_W = 16, CFG_AW = 4;
  localparam int ROWS = DEPTH / (NSEG * LANES);
  localparam int TOT  = NSEG * ROWS;

  typedef struct packed {
    logic       circ;
    logic [1:0] sel;
    logic [15:0] o0, c0, o1, c1;
    logic [7:0] run;
    logic [3:0] evm, evp;
    logic       stall;
    logic       use_err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 16'd2,  16'd4,   16'd6,  16'd7,  8'd10, 4'd1, 4'd0, 1'b0, 1'b0},
    '{1'b0, 2'd1, 16'd0,  16'd0,   16'd0,  16'd0,  8'd12, 4'd3, 4'd0, 1'b1, 1'b1},
    '{1'b0, 2'd2, 16'd0,  16'd5,   16'd4,  16'd11, 8'd14, 4'd2, 4'd1, 1'b0, 1'b0},
    '{1'b0, 2'd0, 16'd0,  16'd20,  16'd30, 16'd40, 8'd15, 4'd1, 4'd0, 1'b1, 1'b0},
    '{1'b1, 2'd0, 16'd0,  16'd100, 16'd0,  16'd0,  8'd20, 4'd1, 4'd0, 1'b0, 1'b0},
    '{1'b1, 2'd1, 16'd0,  16'd0,   16'd0,  16'd0,  8'd20, 4'd4, 4'd1, 1'b1, 1'b1},
    '{1'b0, 2'd0, 16'd50, 16'd60,  16'd50, 16'd60, 8'd5,  4'd1, 4'd0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic start_i = 1'b0, done_i = 1'b0, err_i = 1'b0, event_i = 1'b0;
  logic [LANES*DATA_W-1:0] probe_i = '0;
  logic ser_valid_o, ser_ready_i = 1'b0, ser_data_o;
  logic capturing_o, unloading_o;
  logic [NSEG-1:0] seg_ovf_o;

  always #4 clk = ~clk;

  dbg_trace_capture #(.DATA_W(DATA_W), .LANES(LANES), .NSEG(NSEG), .DEPTH(DEPTH),
    .CNT_W(CNT_W), .CFG_AW(CFG_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start_i(start_i), .done_i(done_i), .err_i(err_i), .probe_i(probe_i), .event_i(event_i),
    .ser_valid_o(ser_valid_o), .ser_ready_i(ser_ready_i), .ser_data_o(ser_data_o),
    .capturing_o(capturing_o), .unloading_o(unloading_o), .seg_ovf_o(seg_ovf_o));

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  int seg_k [NSEG][ROWS];
  int seg_n [NSEG];
  bit seg_ov [NSEG];
  int ring_k [TOT];
  int ring_wp;
  bit ring_wr;
  logic [DATA_W-1:0] exp_w [TOT*LANES];
  int n_exp;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  function automatic logic [DATA_W-1:0] lane_word(int l, int v, int k);
    return {8'(8'hA0 + l), 8'(v), 16'(k)};
  endfunction

  function automatic logic [LANES*DATA_W-1:0] probe_at(int v, int k);
    logic [LANES*DATA_W-1:0] p;
    for (int l = 0; l < LANES; l++) p[l*DATA_W +: DATA_W] = lane_word(l, v, k);
    return p;
  endfunction

  function automatic bit trig(vec_t t, int s, int k);
    bit tw, ev;
    int lo, hi;
    lo = (s == 0) ? int'(t.o0) : int'(t.o1);
    hi = (s == 0) ? int'(t.c0) : int'(t.c1);
    tw = (k >= lo) && (k <= hi);
    ev = (k % int'(t.evm)) == int'(t.evp);
    if (t.sel == 2'd0) return tw;
    if (t.sel == 2'd1) return ev;
    return tw && ev;
  endfunction

  task automatic cfg_write(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = CFG_AW'(a); cfg_wdata = CNT_W'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input int v);
    vec_t t;
    string tag;
    int wi, nb, guard;
    logic [DATA_W-1:0] sh;
    bit pv, pr;
    logic pd;
    t = VECS[v];
    tag = t.circ ? "R5" : "R8";
    cfg_write(0, {t.sel, t.circ});
    cfg_write(2, int'(t.o0)); cfg_write(3, int'(t.c0));
    cfg_write(4, int'(t.o1)); cfg_write(5, int'(t.c1));
    for (int s = 0; s < NSEG; s++) begin seg_n[s] = 0; seg_ov[s] = 1'b0; end
    ring_wp = 0; ring_wr = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 capture entered", 64'(capturing_o), 64'd1);
    for (int k = 0; k < int'(t.run); k++) begin
      probe_i = probe_at(v, k);
      event_i = ((k % int'(t.evm)) == int'(t.evp));
      cfg_we = (k == 1); cfg_addr = 4'd3; cfg_wdata = '0;   // R10: ignored write
      start_i = (k == 2);                                    // R7: ignored start
      if (t.circ) begin
        if (trig(t, 0, k)) begin
          ring_k[ring_wp] = k;
          ring_wp = (ring_wp + 1) % TOT;
          if (ring_wp == 0) ring_wr = 1'b1;
        end
      end else begin
        for (int s = 0; s < NSEG; s++) begin
          if (trig(t, s, k)) begin
            if (seg_n[s] < ROWS) begin seg_k[s][seg_n[s]] = k; seg_n[s]++; end
            else seg_ov[s] = 1'b1;
          end
        end
      end
      @(negedge clk);
    end
    cfg_we = 1'b0; start_i = 1'b0;
    if (t.use_err) err_i = 1'b1; else done_i = 1'b1;
    probe_i = probe_at(v, int'(t.run)); event_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0; err_i = 1'b0; event_i = 1'b0;
    chk("R7 unload after stop", {62'd0, capturing_o, unloading_o}, 64'd1);
    for (int s = 0; s < NSEG; s++) chk("R4 overflow flag", 64'(seg_ovf_o[s]), 64'(seg_ov[s]));
    n_exp = 0;
    if (t.circ) begin
      for (int i = 0; i < (ring_wr ? TOT : ring_wp); i++)
        for (int l = 0; l < LANES; l++)
          exp_w[n_exp++] = lane_word(l, v, ring_k[(ring_wr ? ring_wp + i : i) % TOT]);
    end else begin
      for (int s = 0; s < NSEG; s++)
        for (int i = 0; i < seg_n[s]; i++)
          for (int l = 0; l < LANES; l++) exp_w[n_exp++] = lane_word(l, v, seg_k[s][i]);
    end
    wi = 0; nb = 0; sh = '0; pv = 1'b0; pr = 1'b1; pd = 1'b0; guard = 0;
    while (unloading_o && guard < 20000) begin
      if (pv && !pr) begin
        chk("R9 stall hold", {62'd0, ser_valid_o, ser_data_o}, {62'd0, 1'b1, pd});
      end
      ser_ready_i = t.stall ? (guard % 3 == 2) : 1'b1;
      pv = ser_valid_o; pr = ser_ready_i; pd = ser_data_o;
      if (ser_valid_o && ser_ready_i) begin
        sh = {ser_data_o, sh[DATA_W-1:1]};
        nb++;
        if (nb == DATA_W) begin
          nb = 0;
          if (wi < n_exp) chk({tag, " R6 R9 word"}, 64'(sh), 64'(exp_w[wi]));
          else chk({tag, " extra word"}, 64'(wi), 64'(n_exp));
          wi++;
        end
      end
      guard++;
      @(negedge clk);
    end
    ser_ready_i = 1'b0;
    chk({tag, " word count"}, 64'(wi), 64'(n_exp));
    chk("R9 partial bits", 64'(nb), 64'd0);
    chk("R8 back to idle", {62'd0, unloading_o, ser_valid_o}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset phase", {62'd0, capturing_o, unloading_o}, 64'd0);
    chk("R9 reset serial", 64'(ser_valid_o), 64'd0);
    chk("R4 reset overflow", 64'(seg_ovf_o), 64'd0);
    // R7: done and error while idle are ignored
    done_i = 1'b1; err_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0; err_i = 1'b0;
    @(negedge clk);
    chk("R7 stop ignored in idle", {61'd0, capturing_o, unloading_o, ser_valid_o}, 64'd0);
    // table: R1 R2 R3 R4 R5 R6 R8 R9 R10
    for (int v = 0; v < NV; v++) run_vec(v);
    // R4: next start clears overflow; R8 empty run returns to idle
    cfg_write(0, 0); cfg_write(2, 900); cfg_write(3, 901); cfg_write(4, 900); cfg_write(5, 901);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R4 overflow cleared by start", 64'(seg_ovf_o), 64'd0);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 empty unload done", {61'd0, capturing_o, unloading_o, ser_valid_o}, 64'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule